// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Mapper

This block sits on the CPU write path of a cartridge-style memory map and turns writes into bank selections. Each write carries a 16-bit address and an 8-bit data value. The top three address bits pick one of eight regions, and only the lower four regions are decoded. From these writes the block keeps four things: an external-RAM enable, a 7-bit ROM bank number, a 2-bit RAM bank number and a banking-mode flag.

A single 2-bit register is shared between two uses, and the mode flag picks which one applies. In mode 0 it supplies ROM bank bits [6:5]. In mode 1 it supplies the RAM bank. A write of zero to the low ROM bank field is replaced by one. When the cartridge has fewer banks than the 7-bit number can address, the ROM bank is masked by the bank count minus one, so an out-of-range bank wraps back into range.

The ROM and RAM arrays and the read datapath are outside this block. It only drives the bank selection outputs that feed them.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, `ram_en` is 0, `rom_bank` is 1 and `ram_bank` is 0. The banking mode is 0.
- R2: A write selects its target with `wr_addr[15:13]`. Writes to regions 4 to 7 change no output.
- R3: In region 0, data 0x0A sets `ram_en` to 1 and data 0x00 clears it. Any other data value leaves `ram_en` unchanged.
- R4: In region 1, `wr_data[4:0]` replaces ROM bank bits [4:0] and bits [6:5] are kept. A value of 0 in `wr_data[4:0]` is stored as 1, and `wr_data[7:5]` is ignored.
- R5: In region 2 with mode 0, `wr_data[1:0]` replaces ROM bank bits [6:5] and bits [4:0] are kept.
- R6: In region 2 with mode 1, `wr_data[1:0]` becomes the RAM bank and the ROM bank is unchanged.
- R7: In region 3, `wr_data[0]` becomes the mode. Writing mode 1 clears ROM bank bits [6:5]. Writing mode 0 forces the RAM bank to 0. While mode is 0 the RAM bank reads 0.
- R8: With `ROM_BANKS` banks (a power of two), `rom_bank` equals the stored 7-bit bank number masked by `ROM_BANKS-1`. A bank at or above `ROM_BANKS` therefore wraps into range.
- R9: Outputs are registered. They change on the rising clock edge that samples `wr_en` high, and they hold their value on every edge without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | 16 | Write address; bits [15:13] select the region |
| wr_data | input | 8 | Write data |
| ram_en | output | 1 | External RAM enable |
| rom_bank | output | 7 | Switchable ROM bank number, after wrap |
| ram_bank | output | 2 | External RAM bank number |

## Verification
The bench runs with 64 ROM banks, so that ROM bank bit 5 stays visible and bit 6 wraps away. It checks the following cases:

- A shared value of 2 must fold back to the low bank. A mapper without wrap would report bank 95.
- A low-field write of zero must become one. A mapper without this remap would show bank 0 or a bank with a zero low field.
- Toggling the mode must clear the upper ROM bits and force the RAM bank to zero. A design that routes the shared register wrongly would instead move the ROM bank during a mode-1 RAM select, or keep a stale RAM bank after returning to mode 0.
- Near-miss enable codes and writes to the upper four regions must leave every output untouched.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
   localparam int REGION_COUNT = 4;
   localparam logic [7:0] RAM_ON_CODE  = 8'h0A;
   localparam logic [7:0] RAM_OFF_CODE = 8'h00;

   typedef enum logic [1:0] {
      RGN_RAM_GATE = 2'd0,
      RGN_ROM_LOW  = 2'd1,
      RGN_SHARED   = 2'd2,
      RGN_MODE     = 2'd3
   } cbm_region_e;
endpackage

// File: rtl/cbm_wr_decode.sv
module cbm_wr_decode
   import cbm_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SEL_W  = 3
) (
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   output logic [REGION_COUNT-1:0] sel_o
);
   localparam int LOW_END = ADDR_W - SEL_W;

   logic [SEL_W-1:0] region;

   if (SEL_W < 3 || SEL_W >= ADDR_W) begin : g_bad_sel
      $error("cbm_wr_decode: SEL_W out of range");
   end

   assign region = wr_addr[ADDR_W-1:LOW_END];

   for (genvar i = 0; i < REGION_COUNT; i++) begin : g_strobe
      assign sel_o[i] = wr_en && (region == SEL_W'(i));
   end
endmodule

// File: rtl/cbm_bank_regs.sv
module cbm_bank_regs
   import cbm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LOW_W  = 5,
   parameter int HIGH_W = 2,
   parameter int RAM_W  = 2,
   localparam int ROM_W = LOW_W + HIGH_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [REGION_COUNT-1:0] sel_i,
   input  logic [DATA_W-1:0]       wr_data,
   output logic                    ram_en_q,
   output logic [RAM_W-1:0]        ram_bank_q,
   output logic [ROM_W-1:0]        rom_raw_next
);
   logic [LOW_W-1:0]  low_q,  low_n;
   logic [HIGH_W-1:0] high_q, high_n;
   logic [RAM_W-1:0]  ram_n;
   logic              mode_q, mode_n, en_n;

   if (RAM_W != HIGH_W) begin : g_bad_share
      $error("cbm_bank_regs: shared register needs RAM_W == HIGH_W");
   end
   if (LOW_W > DATA_W || HIGH_W > DATA_W) begin : g_bad_data
      $error("cbm_bank_regs: bank fields wider than data");
   end

   always_comb begin
      low_n  = low_q;
      high_n = high_q;
      ram_n  = ram_bank_q;
      mode_n = mode_q;
      en_n   = ram_en_q;
      if (sel_i[RGN_RAM_GATE]) begin
         if (wr_data == RAM_ON_CODE)       en_n = 1'b1;
         else if (wr_data == RAM_OFF_CODE) en_n = 1'b0;
      end
      if (sel_i[RGN_ROM_LOW]) begin
         if (wr_data[LOW_W-1:0] == '0) low_n = LOW_W'(1);
         else                          low_n = wr_data[LOW_W-1:0];
      end
      if (sel_i[RGN_SHARED]) begin
         if (mode_q) ram_n  = wr_data[RAM_W-1:0];
         else        high_n = wr_data[HIGH_W-1:0];
      end
      if (sel_i[RGN_MODE]) begin
         mode_n = wr_data[0];
         if (wr_data[0]) high_n = '0;
         else            ram_n  = '0;
      end
   end

   assign rom_raw_next = {high_n, low_n};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q      <= LOW_W'(1);
         high_q     <= '0;
         ram_bank_q <= '0;
         mode_q     <= 1'b0;
         ram_en_q   <= 1'b0;
      end else begin
         low_q      <= low_n;
         high_q     <= high_n;
         ram_bank_q <= ram_n;
         mode_q     <= mode_n;
         ram_en_q   <= en_n;
      end
   end

   // R7: in mode 0 the shared register belongs to the ROM bank
   p_mode0_ram_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |-> (ram_bank_q == '0));
   // R7: in mode 1 the upper ROM bits stay cleared
   p_mode1_high_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q |-> (high_q == '0));
   // R4: a low-field write never leaves zero behind
   p_low_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_i[RGN_ROM_LOW] |=> (low_q != '0));
endmodule

// File: rtl/cbm_rom_wrap.sv
module cbm_rom_wrap #(
   parameter int ROM_W     = 7,
   parameter int ROM_BANKS = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ROM_W-1:0] raw_next,
   output logic [ROM_W-1:0] bank_q
);
   localparam int FULL_SPAN = 1 << ROM_W;
   localparam logic [ROM_W-1:0] BANK_MASK = ROM_W'(ROM_BANKS - 1);

   logic [ROM_W-1:0] wrapped;

   if (ROM_BANKS < 2 || ROM_BANKS > FULL_SPAN ||
       (ROM_BANKS & (ROM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("cbm_rom_wrap: ROM_BANKS must be a power of two in range");
   end

   if (ROM_BANKS == FULL_SPAN) begin : g_no_wrap
      assign wrapped = raw_next;
   end else begin : g_mask_wrap
      assign wrapped = raw_next & BANK_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q <= ROM_W'(1);
      else        bank_q <= wrapped;
   end

   // R8: the reported bank never leaves the populated range
   p_bank_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, bank_q} < (ROM_W+1)'(ROM_BANKS)));
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
   import cbm_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int SEL_W     = 3,
   parameter int LOW_W     = 5,
   parameter int HIGH_W    = 2,
   parameter int RAM_W     = 2,
   parameter int ROM_BANKS = 128,
   localparam int ROM_W    = LOW_W + HIGH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              ram_en,
   output logic [ROM_W-1:0]  rom_bank,
   output logic [RAM_W-1:0]  ram_bank
);
   logic [REGION_COUNT-1:0] sel;
   logic [ROM_W-1:0]        raw_next;

   cbm_wr_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_decode (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .sel_o   (sel)
   );

   cbm_bank_regs #(.DATA_W(DATA_W), .LOW_W(LOW_W), .HIGH_W(HIGH_W),
                   .RAM_W(RAM_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel_i        (sel),
      .wr_data      (wr_data),
      .ram_en_q     (ram_en),
      .ram_bank_q   (ram_bank),
      .rom_raw_next (raw_next)
   );

   cbm_rom_wrap #(.ROM_W(ROM_W), .ROM_BANKS(ROM_BANKS)) u_wrap (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_next (raw_next),
      .bank_q   (rom_bank)
   );

   // R9: no strobe, no change
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(ram_en) && $stable(rom_bank) && $stable(ram_bank)));
   // R2: upper regions are not decoded
   p_region_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[ADDR_W-1]) |=>
      ($stable(ram_en) && $stable(rom_bank) && $stable(ram_bank)));
   // R3: only the two gate codes move the enable
   p_gate_other_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[ADDR_W-1:ADDR_W-SEL_W] == '0 &&
       wr_data != RAM_ON_CODE && wr_data != RAM_OFF_CODE) |=> $stable(ram_en));
endmodule

// File: tb/cart_bank_mapper_tb.sv
module cart_bank_mapper_tb;
   localparam int BANKS = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        ram_en;
   logic [6:0]  rom_bank;
   logic [1:0]  ram_bank;

   int n_cmp = 0;
   int n_bad = 0;
   string cur_req = "R1";

   // reference state
   int m_en, m_rom, m_ram, m_mode;

   always #4 clk = ~clk;

   cart_bank_mapper #(.ROM_BANKS(BANKS)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ram_en(ram_en), .rom_bank(rom_bank),
      .ram_bank(ram_bank)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = 0; m_rom = 1; m_ram = 0; m_mode = 0;
      end else if (wr_en) begin
         case (int'(wr_addr) / 8192)
            0: if (wr_data == 8'h0A) m_en = 1; else if (wr_data == 8'h00) m_en = 0;
            1: m_rom = (m_rom / 32) * 32 + ((int'(wr_data) % 32 == 0) ? 1 : int'(wr_data) % 32);
            2: if (m_mode == 1) m_ram = int'(wr_data) % 4;
               else m_rom = (int'(wr_data) % 4) * 32 + m_rom % 32;
            3: begin
               m_mode = int'(wr_data) % 2;
               if (m_mode == 1) m_rom = m_rom % 32; else m_ram = 0;
            end
            default: ;
         endcase
      end
   end

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk({cur_req, " ram_en"}, int'(ram_en), m_en);
         chk({cur_req, " rom_bank"}, int'(rom_bank), m_rom % BANKS);
         chk({cur_req, " ram_bank"}, int'(ram_bank), m_ram);
      end
   end

   task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
      @(negedge clk);
      cur_req = req;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      #1;
      chk("R9 pre-edge rom_bank", int'(rom_bank), m_rom % BANKS);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic expect_out(string req, int en, int rom, int ram);
      chk({req, " ram_en"}, int'(ram_en), en);
      chk({req, " rom_bank"}, int'(rom_bank), rom);
      chk({req, " ram_bank"}, int'(ram_bank), ram);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_out("R1", 0, 1, 0);

      wr(16'h0000, 8'h0A, "R3"); expect_out("R3", 1, 1, 0);
      wr(16'h1FFF, 8'h55, "R3"); expect_out("R3", 1, 1, 0);
      wr(16'h0100, 8'h00, "R3"); expect_out("R3", 0, 1, 0);
      wr(16'h0000, 8'h0A, "R3");
      wr(16'h0000, 8'h8A, "R3"); expect_out("R3", 1, 1, 0);

      wr(16'h2000, 8'h00, "R4"); expect_out("R4", 1, 1, 0);
      wr(16'h3000, 8'hE5, "R4"); expect_out("R4", 1, 5, 0);
      wr(16'h2000, 8'h1F, "R4"); expect_out("R4", 1, 31, 0);

      wr(16'h4000, 8'h01, "R5"); expect_out("R5", 1, 63, 0);
      wr(16'h4000, 8'h02, "R8"); expect_out("R8", 1, 31, 0);
      wr(16'h4000, 8'h03, "R8"); expect_out("R8", 1, 63, 0);
      wr(16'h2000, 8'h07, "R4"); expect_out("R4", 1, 39, 0);

      wr(16'h8000, 8'h00, "R2"); expect_out("R2", 1, 39, 0);
      wr(16'hA000, 8'h01, "R2"); expect_out("R2", 1, 39, 0);
      wr(16'hE000, 8'h01, "R2"); expect_out("R2", 1, 39, 0);

      wr(16'h6000, 8'h01, "R7"); expect_out("R7", 1, 7, 0);
      wr(16'h4000, 8'h02, "R6"); expect_out("R6", 1, 7, 2);
      wr(16'h5FFF, 8'hFF, "R6"); expect_out("R6", 1, 7, 3);
      wr(16'h6000, 8'hFE, "R7"); expect_out("R7", 1, 7, 0);
      wr(16'h4000, 8'h01, "R5"); expect_out("R5", 1, 39, 0);

      cur_req = "R9";
      repeat (4) @(negedge clk);
      expect_out("R9", 1, 39, 0);

      for (int i = 0; i < 600; i++) begin
         logic [15:0] a;
         logic [7:0]  d;
         a = 16'($urandom);
         d = (($urandom % 4) == 0) ? 8'h0A : 8'($urandom);
         if (($urandom % 3) == 0) d = d % 8'd4;
         wr(a, d, "R2/R3/R4/R5/R6/R7/R8 random");
         if (($urandom % 4) == 0) @(negedge clk);
      end

      @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule